// File: doc/BRIEF.md
# Camera Receiver Control Register Block

This block is the software-visible control plane of a serial camera receiver. A host reaches it over a plain 32-bit register bus, made of a word address, write data, a write strobe, a read strobe and registered read data. Through it the host reads a fixed capability word, holds the receiver's front end and protocol layer in reset, programs the lane mapping word and the PHY lane enable/reset word, and configures and commands each output stream. The configuration words go out of the block as level signals to the datapath, which is not part of this block.

Every output stream owns a page of four registers: command, status, channel selection and buffering mode. A small controller in each page turns the start and stop commands into a ready flag. After a stop the flag stays up until the stream's datapath pulses its drain-complete input, so software polling the status word sees ready fall only once the stream is truly empty. A stream-level soft reset bit drops the stream to idle at once and holds it there for as long as the bit stays set.

Top module: `cam_rx_regs`

## Requirements
- R1: Offset 0x000 is read-only and returns the capability word: bits 2:0 the lane count (MAX_LANES), bit 3 the internal-PHY flag (HAS_INT_PHY), bits 6:4 the stream count (NUM_STREAMS), all other bits zero; with defaults it reads 0x0000_0044 and writes leave it unchanged.
- R2: Offset 0x004 holds two reset bits: bit 0 drives `front_rst`, bit 1 drives `proto_rst`; each output stays high while its bit is set, and the other bits read zero.
- R3: Offset 0x008 (lane mapping) and offset 0x040 (PHY lane enable/reset) are full 32-bit read/write words whose contents drive `lane_cfg` and `phy_lane_ctrl`.
- R4: Stream n (0-based) occupies the page at byte address (n+1)*0x100, with command at +0x0, status at +0x4, channel selection at +0x8 and buffering mode at +0xC; each stream's page affects only that stream.
- R5: In the channel selection word, bit 16+v enables virtual channel v (v below NUM_VC) and drives `strm_vc_en`; in the buffering word, bit 8 selects the large FIFO mode and drives `strm_big_fifo`; all other bits of both read zero.
- R6: Writing command bit 0 (start) to an idle stream raises its ready flag (`strm_running` bit and status bit 31) in the cycle after the write edge.
- R7: Writing command bit 1 (stop) to a running stream leaves ready set until that stream's `drain_done` bit pulses; ready clears in the cycle after the pulse edge.
- R8: A `drain_done` pulse on a stream that is not stopping, a stop on an idle stream, and a start on a running stream have no effect.
- R9: Command bit 4 is a level-held stream reset: while it is set the stream is idle, ready is clear, starts are ignored and `strm_soft_rst` is high; command bits 0 and 1 are not stored, so the command word reads back only bit 4.
- R10: Reads of any unmapped offset return zero and writes to them change no register.
- R11: `bus_rdata` is registered: it shows the addressed word in the cycle after the edge that samples `bus_re`, and is zero after any edge where `bus_re` was low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register bus and control clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| drain_done | input | NUM_STREAMS | Per-stream pulse: datapath has drained after stop |
| front_rst | output | 1 | Front-end reset, level |
| proto_rst | output | 1 | Protocol-layer reset, level |
| lane_cfg | output | 32 | Lane mapping word |
| phy_lane_ctrl | output | 32 | PHY lane enable/reset word |
| strm_running | output | NUM_STREAMS | Per-stream ready flag |
| strm_soft_rst | output | NUM_STREAMS | Per-stream reset, level |
| strm_vc_en | output | NUM_STREAMS*NUM_VC | Virtual channel enables, stream-major |
| strm_big_fifo | output | NUM_STREAMS | Per-stream large FIFO mode |

## Verification
On every cycle the assertions check that a stream's ready flag rises only after a start write to its own page, falls only after that stream's drain pulse or while its reset is held, is never set during a held stream reset, that the global reset outputs move only after a write to their register, that the capability word reads back unchanged, and that read data is zero after a cycle without a read strobe. Only the bench's scenarios show the values written and read back through each offset, that ready persists across a stop until the drain pulse, that stray drain pulses and stop commands leave a stream untouched, that a start during a held reset is lost, and that unmapped writes leave every register unchanged.

// File: rtl/cam_rx_pkg.sv
package cam_rx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2
  } strm_st_e;

  // Global page offsets (low byte of the address)
  localparam logic [7:0] OFS_CAP  = 8'h00;
  localparam logic [7:0] OFS_SRST = 8'h04;
  localparam logic [7:0] OFS_LANE = 8'h08;
  localparam logic [7:0] OFS_PHY  = 8'h40;

  // Stream page offsets
  localparam logic [7:0] OFS_CMD  = 8'h00;
  localparam logic [7:0] OFS_STAT = 8'h04;
  localparam logic [7:0] OFS_CHAN = 8'h08;
  localparam logic [7:0] OFS_BUF  = 8'h0C;

  // Bit positions
  localparam int CMD_GO    = 0;
  localparam int CMD_HALT  = 1;
  localparam int CMD_HOLD  = 4;
  localparam int STAT_RDY  = 31;
  localparam int BUF_BIG   = 8;
  localparam int CHAN_LSB  = 16;

endpackage

// File: rtl/cam_stream_fsm.sv
module cam_stream_fsm
  import cam_rx_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic go,
  input  logic halt,
  input  logic hold,
  input  logic drained,
  output logic ready
);

  strm_st_e st_q;

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      st_q <= ST_IDLE;
    end else begin
      unique case (st_q)
        ST_IDLE:  if (go)      st_q <= ST_RUN;
        ST_RUN:   if (halt)    st_q <= ST_DRAIN;
        ST_DRAIN: if (drained) st_q <= ST_IDLE;
        default:               st_q <= ST_IDLE;
      endcase
    end
  end

  assign ready = (st_q != ST_IDLE);

endmodule

// File: rtl/cam_glob_regs.sv
module cam_glob_regs
  import cam_rx_pkg::*;
#(
  parameter int MAX_LANES   = 4,
  parameter int NUM_STREAMS = 4,
  parameter bit HAS_INT_PHY = 1'b0
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        sel,
  input  logic [7:0]  ofs,
  input  logic        we,
  input  logic [31:0] wdata,
  output logic [31:0] rdata_c,
  output logic        front_rst,
  output logic        proto_rst,
  output logic [31:0] lane_cfg,
  output logic [31:0] phy_lane_ctrl
);

  localparam logic [2:0]  LANE_F = 3'(MAX_LANES);
  localparam logic [2:0]  STRM_F = 3'(NUM_STREAMS);
  localparam logic [31:0] CAP    = {25'd0, STRM_F, HAS_INT_PHY, LANE_F};

  logic [1:0] srst_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      srst_q        <= '0;
      lane_cfg      <= '0;
      phy_lane_ctrl <= '0;
    end else if (sel && we) begin
      case (ofs)
        OFS_SRST: srst_q        <= wdata[1:0];
        OFS_LANE: lane_cfg      <= wdata;
        OFS_PHY:  phy_lane_ctrl <= wdata;
        default: ;
      endcase
    end
  end

  assign front_rst = srst_q[0];
  assign proto_rst = srst_q[1];

  always_comb begin
    rdata_c = '0;
    if (sel) begin
      case (ofs)
        OFS_CAP:  rdata_c = CAP;
        OFS_SRST: rdata_c = {30'd0, srst_q};
        OFS_LANE: rdata_c = lane_cfg;
        OFS_PHY:  rdata_c = phy_lane_ctrl;
        default:  rdata_c = '0;
      endcase
    end
  end

endmodule

// File: rtl/cam_stream_slot.sv
module cam_stream_slot
  import cam_rx_pkg::*;
#(
  parameter int NUM_VC = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic [7:0]        ofs,
  input  logic              we,
  input  logic [31:0]       wdata,
  input  logic              drained,
  output logic [31:0]       rdata_c,
  output logic              ready,
  output logic              soft_rst,
  output logic [NUM_VC-1:0] vc_en,
  output logic              big_fifo
);

  localparam int VC_MSB = CHAN_LSB + NUM_VC - 1;

  logic cmd_wr;
  assign cmd_wr = sel && we && (ofs == OFS_CMD);

  always_ff @(posedge clk) begin
    if (rst) begin
      soft_rst <= 1'b0;
      vc_en    <= '0;
      big_fifo <= 1'b0;
    end else if (sel && we) begin
      case (ofs)
        OFS_CMD:  soft_rst <= wdata[CMD_HOLD];
        OFS_CHAN: vc_en    <= wdata[VC_MSB:CHAN_LSB];
        OFS_BUF:  big_fifo <= wdata[BUF_BIG];
        default: ;
      endcase
    end
  end

  cam_stream_fsm u_fsm (
    .clk     (clk),
    .rst     (rst),
    .go      (cmd_wr && wdata[CMD_GO]),
    .halt    (cmd_wr && wdata[CMD_HALT]),
    .hold    (soft_rst || (cmd_wr && wdata[CMD_HOLD])),
    .drained (drained),
    .ready   (ready)
  );

  always_comb begin
    rdata_c = '0;
    if (sel) begin
      case (ofs)
        OFS_CMD:  rdata_c[CMD_HOLD]         = soft_rst;
        OFS_STAT: rdata_c[STAT_RDY]         = ready;
        OFS_CHAN: rdata_c[VC_MSB:CHAN_LSB]  = vc_en;
        OFS_BUF:  rdata_c[BUF_BIG]          = big_fifo;
        default:  rdata_c = '0;
      endcase
    end
  end

endmodule

// File: rtl/cam_rx_regs.sv
module cam_rx_regs #(
  parameter int ADDR_W      = 12,
  parameter int NUM_STREAMS = 4,
  parameter int MAX_LANES   = 4,
  parameter int NUM_VC      = 4,
  parameter bit HAS_INT_PHY = 1'b0
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic [31:0]                   bus_wdata,
  input  logic                          bus_we,
  input  logic                          bus_re,
  output logic [31:0]                   bus_rdata,
  input  logic [NUM_STREAMS-1:0]        drain_done,
  output logic                          front_rst,
  output logic                          proto_rst,
  output logic [31:0]                   lane_cfg,
  output logic [31:0]                   phy_lane_ctrl,
  output logic [NUM_STREAMS-1:0]        strm_running,
  output logic [NUM_STREAMS-1:0]        strm_soft_rst,
  output logic [NUM_STREAMS*NUM_VC-1:0] strm_vc_en,
  output logic [NUM_STREAMS-1:0]        strm_big_fifo
);

  localparam int PAGE_W = ADDR_W - 8;

  logic [PAGE_W-1:0] page;
  logic [7:0]        ofs;
  logic [31:0]       glob_rd;
  logic [31:0]       slot_rd [NUM_STREAMS];
  logic [31:0]       rd_mux;

  assign page = bus_addr[ADDR_W-1:8];
  assign ofs  = bus_addr[7:0];

  cam_glob_regs #(
    .MAX_LANES   (MAX_LANES),
    .NUM_STREAMS (NUM_STREAMS),
    .HAS_INT_PHY (HAS_INT_PHY)
  ) u_glob (
    .clk           (clk),
    .rst           (rst),
    .sel           (page == '0),
    .ofs           (ofs),
    .we            (bus_we),
    .wdata         (bus_wdata),
    .rdata_c       (glob_rd),
    .front_rst     (front_rst),
    .proto_rst     (proto_rst),
    .lane_cfg      (lane_cfg),
    .phy_lane_ctrl (phy_lane_ctrl)
  );

  for (genvar n = 0; n < NUM_STREAMS; n++) begin : g_slot
    cam_stream_slot #(.NUM_VC(NUM_VC)) u_slot (
      .clk      (clk),
      .rst      (rst),
      .sel      (page == PAGE_W'(n + 1)),
      .ofs      (ofs),
      .we       (bus_we),
      .wdata    (bus_wdata),
      .drained  (drain_done[n]),
      .rdata_c  (slot_rd[n]),
      .ready    (strm_running[n]),
      .soft_rst (strm_soft_rst[n]),
      .vc_en    (strm_vc_en[n*NUM_VC +: NUM_VC]),
      .big_fifo (strm_big_fifo[n])
    );
  end

  always_comb begin
    rd_mux = glob_rd;
    for (int n = 0; n < NUM_STREAMS; n++) rd_mux = rd_mux | slot_rd[n];
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_re) bus_rdata <= rd_mux;
    else             bus_rdata <= '0;
  end

endmodule

// File: rtl/cam_rx_regs_chk.sv
module cam_rx_regs_chk #(
  parameter int ADDR_W      = 12,
  parameter int NUM_STREAMS = 4,
  parameter int MAX_LANES   = 4,
  parameter int NUM_VC      = 4,
  parameter bit HAS_INT_PHY = 1'b0
) (
  input logic                          clk,
  input logic                          rst,
  input logic [ADDR_W-1:0]             bus_addr,
  input logic [31:0]                   bus_wdata,
  input logic                          bus_we,
  input logic                          bus_re,
  input logic [31:0]                   bus_rdata,
  input logic [NUM_STREAMS-1:0]        drain_done,
  input logic                          front_rst,
  input logic                          proto_rst,
  input logic [31:0]                   lane_cfg,
  input logic [31:0]                   phy_lane_ctrl,
  input logic [NUM_STREAMS-1:0]        strm_running,
  input logic [NUM_STREAMS-1:0]        strm_soft_rst,
  input logic [NUM_STREAMS*NUM_VC-1:0] strm_vc_en,
  input logic [NUM_STREAMS-1:0]        strm_big_fifo
);

  localparam logic [31:0] CAP_EXP =
    {25'd0, 3'(NUM_STREAMS), HAS_INT_PHY, 3'(MAX_LANES)};

  // R1: capability word reads back constant
  p_cap_fixed_r1: assert property (@(posedge clk) disable iff (rst)
    (bus_re && bus_addr == '0) |=> (bus_rdata == CAP_EXP));

  // R2: global reset outputs move only after a write to their register
  p_srst_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !(bus_we && bus_addr == ADDR_W'(4)) |=> ($stable(front_rst) && $stable(proto_rst)));

  // R11: no read strobe, zero read data
  p_rd_idle_r11: assert property (@(posedge clk) disable iff (rst)
    !bus_re |=> (bus_rdata == '0));

  for (genvar i = 0; i < NUM_STREAMS; i++) begin : g_s
    // R6: ready rises only after a start write to this stream's command word
    p_rise_start_r6: assert property (@(posedge clk) disable iff (rst)
      $rose(strm_running[i]) |->
        $past(bus_we && bus_addr == ADDR_W'((i + 1) * 256) && bus_wdata[0]));

    // R7: ready falls only after a drain pulse or under stream reset
    p_fall_drain_r7: assert property (@(posedge clk) disable iff (rst)
      $fell(strm_running[i]) |-> ($past(drain_done[i]) || strm_soft_rst[i]));

    // R9: held stream reset keeps ready clear
    p_hold_idle_r9: assert property (@(posedge clk) disable iff (rst)
      strm_soft_rst[i] |-> !strm_running[i]);
  end

endmodule

bind cam_rx_regs cam_rx_regs_chk #(
  .ADDR_W      (ADDR_W),
  .NUM_STREAMS (NUM_STREAMS),
  .MAX_LANES   (MAX_LANES),
  .NUM_VC      (NUM_VC),
  .HAS_INT_PHY (HAS_INT_PHY)
) u_chk (.*);

// File: tb/sim_cam_rx_regs.sv
module sim_cam_rx_regs;

  localparam int NS = 4;
  localparam int NV = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic        bus_re = 1'b0;
  logic [31:0] bus_rdata;
  logic [NS-1:0] drain_done = '0;
  logic        front_rst, proto_rst;
  logic [31:0] lane_cfg, phy_lane_ctrl;
  logic [NS-1:0] strm_running, strm_soft_rst, strm_big_fifo;
  logic [NS*NV-1:0] strm_vc_en;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  cam_rx_regs u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .drain_done(drain_done), .front_rst(front_rst), .proto_rst(proto_rst),
    .lane_cfg(lane_cfg), .phy_lane_ctrl(phy_lane_ctrl),
    .strm_running(strm_running), .strm_soft_rst(strm_soft_rst),
    .strm_vc_en(strm_vc_en), .strm_big_fifo(strm_big_fifo)
  );

  // {is_write, addr, wdata, expected read}
  localparam int NVEC = 22;
  localparam logic [76:0] VEC [NVEC] = '{
    {1'b0, 12'h000, 32'h0,          32'h0000_0044},  // R1
    {1'b1, 12'h000, 32'hFFFF_FFFF,  32'h0},          // R1 write ignored
    {1'b0, 12'h000, 32'h0,          32'h0000_0044},  // R1
    {1'b1, 12'h008, 32'h3210_0400,  32'h0},          // R3
    {1'b0, 12'h008, 32'h0,          32'h3210_0400},  // R3
    {1'b1, 12'h040, 32'h0001_F00F,  32'h0},          // R3
    {1'b0, 12'h040, 32'h0,          32'h0001_F00F},  // R3
    {1'b1, 12'h004, 32'hFFFF_FFFE,  32'h0},          // R2
    {1'b0, 12'h004, 32'h0,          32'h0000_0002},  // R2
    {1'b1, 12'h108, 32'hFFFF_FFFF,  32'h0},          // R5
    {1'b0, 12'h108, 32'h0,          32'h000F_0000},  // R5
    {1'b1, 12'h30C, 32'hFFFF_FFFF,  32'h0},          // R5
    {1'b0, 12'h30C, 32'h0,          32'h0000_0100},  // R5
    {1'b0, 12'h10C, 32'h0,          32'h0},          // R4 other stream untouched
    {1'b0, 12'h104, 32'h0,          32'h0},          // R4 idle status
    {1'b1, 12'h00C, 32'hFFFF_FFFF,  32'h0},          // R10
    {1'b1, 12'h080, 32'hFFFF_FFFF,  32'h0},          // R10
    {1'b1, 12'h500, 32'hFFFF_FFFF,  32'h0},          // R10
    {1'b0, 12'h008, 32'h0,          32'h3210_0400},  // R10 lane word kept
    {1'b0, 12'h080, 32'h0,          32'h0},          // R10
    {1'b0, 12'h500, 32'h0,          32'h0},          // R10
    {1'b0, 12'h110, 32'h0,          32'h0}           // R10
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk);
    d = bus_rdata;
    bus_re = 1'b0;
  endtask

  task automatic drain(input int s);
    @(negedge clk);
    drain_done[s] = 1'b1;
    @(negedge clk);
    drain_done[s] = 1'b0;
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset state
    chk("R2 reset front", {31'd0, front_rst}, 32'd0);
    chk("R6 reset running", {28'd0, strm_running}, 32'd0);
    chk("R11 reset rdata", bus_rdata, 32'd0);

    for (int k = 0; k < NVEC; k++) begin
      if (VEC[k][76]) wr(VEC[k][75:64], VEC[k][63:32]);
      else begin
        rd(VEC[k][75:64], r);
        chk($sformatf("R1-vector %0d (R10 R5 R3 R2)", k), r, VEC[k][31:0]);
      end
    end
    chk("R2 proto_rst level", {30'd0, proto_rst, front_rst}, 32'd2);
    chk("R3 lane_cfg out", lane_cfg, 32'h3210_0400);
    chk("R5 vc_en out", {16'd0, strm_vc_en}, 32'h0000_000F);
    chk("R5 big fifo out", {28'd0, strm_big_fifo}, 32'h4);
    wr(12'h004, 32'h0);
    chk("R2 release", {30'd0, proto_rst, front_rst}, 32'd0);

    // R11: rdata zero the cycle after re drops
    @(negedge clk);
    chk("R11 idle rdata", bus_rdata, 32'd0);

    // R6 / R7 start, stop, drain on stream 0
    wr(12'h100, 32'h1);
    chk("R6 start ready", {28'd0, strm_running}, 32'h1);
    rd(12'h104, r);
    chk("R6 status bit31", r, 32'h8000_0000);
    rd(12'h100, r);
    chk("R9 cmd bits not stored", r, 32'h0);
    wr(12'h100, 32'h2);
    chk("R7 ready held while draining", {28'd0, strm_running}, 32'h1);
    repeat (3) @(negedge clk);
    chk("R7 still held", {28'd0, strm_running}, 32'h1);
    drain(0);
    chk("R7 ready cleared", {28'd0, strm_running}, 32'h0);
    rd(12'h104, r);
    chk("R7 status clear", r, 32'h0);

    // R8: drain while running, stop in idle
    wr(12'h200, 32'h1);
    drain(1);
    chk("R8 drain in run ignored", {28'd0, strm_running}, 32'h2);
    wr(12'h200, 32'h1);
    chk("R8 start in run ignored", {28'd0, strm_running}, 32'h2);
    wr(12'h400, 32'h2);
    drain(3);
    chk("R8 stop in idle ignored", {28'd0, strm_running}, 32'h2);
    wr(12'h400, 32'h1);
    chk("R8 later start works", {28'd0, strm_running}, 32'hA);

    // R9: stream reset on running stream 1
    wr(12'h200, 32'h10);
    chk("R9 reset clears ready", {28'd0, strm_running}, 32'h8);
    chk("R9 soft_rst out", {28'd0, strm_soft_rst}, 32'h2);
    wr(12'h200, 32'h11);
    chk("R9 start blocked", {28'd0, strm_running}, 32'h8);
    rd(12'h200, r);
    chk("R9 cmd readback", r, 32'h0000_0010);
    wr(12'h200, 32'h0);
    chk("R9 release", {28'd0, strm_soft_rst}, 32'h0);
    chk("R9 stays idle", {28'd0, strm_running}, 32'h8);

    // R4: stream 3 page independent of stream 2
    rd(12'h304, r);
    chk("R4 stream2 status", r, 32'h0);
    rd(12'h404, r);
    chk("R4 stream3 status", r, 32'h8000_0000);

    finish_run();
  end

endmodule